// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit for a 32-bit RISC-V Core

This block computes the result of one integer instruction of the register-register or register-immediate class. The decode stage hands it two operands, the 3-bit operation field, the single instruction bit that picks subtract or arithmetic shift, a flag saying whether the second operand is an immediate, and the destination register index. The block returns the result and a write enable for the register file in the same cycle. It holds no state.

The second operand is already muxed by the caller. For immediate forms it is the sign-extended immediate. Shifts look only at its low bits. Subtraction exists only in the register-register form, so the alternate bit is ignored for an immediate add. The write enable drops whenever the destination is register zero.

The shifter comes in two variants, chosen by a parameter. One is a logarithmic stage chain that reuses a single right-shift path for left shifts by reversing the bits. The other is the plain operator form, which leaves the structure to synthesis.

Top module: `rv_int_alu`

## Requirements
- R1: Operation code 0 adds (when not subtracting), 4 gives bitwise XOR, 6 gives bitwise OR and 7 gives bitwise AND. Additions wrap modulo 2^32.
- R2: Operation code 1 shifts the first operand left, filling with zeros. Only the low 5 bits of the second operand set the shift amount.
- R3: For operation code 5, an alternate bit of 1 gives an arithmetic (sign-filling) right shift and 0 gives a logical right shift. This holds in both immediate and register forms, with the amount from the low 5 bits of the second operand.
- R4: For operation code 0 in register form (immediate flag 0), an alternate bit of 1 gives first operand minus second operand. With the immediate flag at 1, operation code 0 always adds, whatever the alternate bit.
- R5: Operation code 2 gives 1 if the first operand is less than the second as signed two's-complement values, else 0. Operation code 3 does the same compare as unsigned, and treats a sign-extended immediate as unsigned. Both results are zero-extended to 32 bits.
- R6: The write enable is 0 when the destination index is 0, and 1 for any other index.
- R7: A right shift of either kind by an amount of 0 returns the first operand unchanged. The result follows the inputs in the same cycle, with no clock edge between them.
- R8: The alternate bit has no effect for operation codes 1, 2, 3, 4, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (source register value) |
| opnd_b | input | 32 | Second operand: register value, or sign-extended immediate |
| op_sel | input | 3 | Operation code from the instruction's 3-bit function field |
| alt_sel | input | 1 | Instruction bit 30: subtract / arithmetic-shift select |
| use_imm | input | 1 | 1 when the second operand is an immediate |
| dest_idx | input | 5 | Destination register index |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Register-file write enable |

## Verification
The embedded checks are evaluated whenever the inputs change. They assume every input is driven to a known value, because a check over an unknown operand has no meaning. They also assume the operand, operation and flag inputs settle together as one instruction. The bench therefore applies each full input set at once on the falling clock edge and reads the outputs a short time later. The table covers every operation code with both settings of the immediate flag where that flag matters. The directed part adds shift amounts whose upper bits are set, so that the 5-bit masking is exercised.

// File: rtl/rv_int_alu_pkg.sv
package rv_int_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SLL  = 3'd1,
      OP_SLT  = 3'd2,
      OP_SLTU = 3'd3,
      OP_XOR  = 3'd4,
      OP_SR   = 3'd5,
      OP_OR   = 3'd6,
      OP_AND  = 3'd7
   } alu_op_e;

   typedef enum int {
      SHIFT_STAGED   = 0,
      SHIFT_OPERATOR = 1
   } shift_impl_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] lhs,
   input  logic [XLEN-1:0] rhs,
   input  logic            sub_en,
   output logic [XLEN-1:0] sum
);
   logic [XLEN-1:0] rhs_eff;
   logic [XLEN-1:0] cin_vec;

   assign rhs_eff = rhs ^ {XLEN{sub_en}};
   assign cin_vec = {{(XLEN-1){1'b0}}, sub_en};
   assign sum     = lhs + rhs_eff + cin_vec;

   always_comb begin
      if (!sub_en && rhs == '0)
         AST_ADD_IDENTITY: assert (sum == lhs) else $error("add of zero changed operand"); // R1
   end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] lhs,
   input  logic [XLEN-1:0] rhs,
   output logic            lt_signed,
   output logic            lt_unsigned
);
   localparam int MSB = XLEN - 1;

   logic [XLEN:0] diff;

   assign diff        = {1'b0, lhs} - {1'b0, rhs};
   assign lt_unsigned = diff[XLEN];
   assign lt_signed   = (lhs[MSB] ^ rhs[MSB]) ? lhs[MSB] : diff[MSB];

   always_comb begin
      if (lhs == rhs)
         AST_EQ_NOT_LESS: assert (!lt_signed && !lt_unsigned) else $error("equal operands compared less"); // R5
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
   import rv_int_alu_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter shift_impl_e SHIFT_IMPL = SHIFT_STAGED,
   localparam int         SHAMT_W    = $clog2(XLEN)
) (
   input  logic [XLEN-1:0]    din,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic               go_left,
   input  logic               arith,
   output logic [XLEN-1:0]    dout
);
   localparam int MSB = XLEN - 1;

   logic fill;
   assign fill = arith & ~go_left & din[MSB];

   function automatic logic [XLEN-1:0] bit_rev(input logic [XLEN-1:0] v);
      logic [XLEN-1:0] r;
      for (int i = 0; i < XLEN; i++) r[i] = v[MSB-i];
      return r;
   endfunction

   generate
      if (SHIFT_IMPL == SHIFT_STAGED) begin : g_staged
         logic [SHAMT_W:0][XLEN-1:0] stg;
         assign stg[0] = go_left ? bit_rev(din) : din;
         for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
            localparam int STEP = 2 ** s;
            assign stg[s+1] = shamt[s] ? {{STEP{fill}}, stg[s][XLEN-1:STEP]} : stg[s];
         end
         assign dout = go_left ? bit_rev(stg[SHAMT_W]) : stg[SHAMT_W];
      end else begin : g_operator
         logic [XLEN:0] ext_r;
         assign ext_r = $signed({fill, din}) >>> shamt;
         assign dout  = go_left ? (din << shamt) : ext_r[XLEN-1:0];
      end
   endgenerate

   always_comb begin
      if (shamt == '0)
         AST_ZERO_SHIFT: assert (dout == din) else $error("shift by zero altered data"); // R7
      if (!go_left && arith && din[MSB])
         AST_SIGN_FILL: assert (dout[MSB]) else $error("arithmetic shift lost sign"); // R3
   end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import rv_int_alu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] lhs,
   input  logic [XLEN-1:0] rhs,
   input  alu_op_e         op,
   output logic [XLEN-1:0] dout
);
   always_comb begin
      unique case (op)
         OP_XOR:  dout = lhs ^ rhs;
         OP_OR:   dout = lhs | rhs;
         default: dout = lhs & rhs;
      endcase
   end

   always_comb begin
      if (op == OP_OR)
         AST_OR_COVERS: assert ((dout & lhs) == lhs) else $error("or result drops bits"); // R1
   end
endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
   import rv_int_alu_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          REG_IDX_W  = 5,
   parameter shift_impl_e SHIFT_IMPL = SHIFT_STAGED,
   localparam int         SHAMT_W    = $clog2(XLEN)
) (
   input  logic [XLEN-1:0]      opnd_a,
   input  logic [XLEN-1:0]      opnd_b,
   input  logic [2:0]           op_sel,
   input  logic                 alt_sel,
   input  logic                 use_imm,
   input  logic [REG_IDX_W-1:0] dest_idx,
   output logic [XLEN-1:0]      result,
   output logic                 wr_en
);
   generate
      if (XLEN < 2 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
         $error("XLEN must be a power of two of at least 2");
      end
      if (REG_IDX_W < 1) begin : g_bad_idx
         $error("REG_IDX_W must be at least 1");
      end
   endgenerate

   alu_op_e op;
   logic    do_sub;
   logic [XLEN-1:0] sum_w, shift_w, logic_w;
   logic    lt_s, lt_u;

   assign op     = alu_op_e'(op_sel);
   assign do_sub = (op == OP_ADD) & alt_sel & ~use_imm;

   alu_addsub #(.XLEN(XLEN)) i_addsub (
      .lhs(opnd_a), .rhs(opnd_b), .sub_en(do_sub), .sum(sum_w)
   );

   alu_compare #(.XLEN(XLEN)) i_compare (
      .lhs(opnd_a), .rhs(opnd_b), .lt_signed(lt_s), .lt_unsigned(lt_u)
   );

   alu_shifter #(.XLEN(XLEN), .SHIFT_IMPL(SHIFT_IMPL)) i_shifter (
      .din(opnd_a), .shamt(opnd_b[SHAMT_W-1:0]),
      .go_left(op == OP_SLL), .arith(alt_sel), .dout(shift_w)
   );

   alu_logic #(.XLEN(XLEN)) i_logic (
      .lhs(opnd_a), .rhs(opnd_b), .op(op), .dout(logic_w)
   );

   always_comb begin
      unique case (op)
         OP_ADD:         result = sum_w;
         OP_SLL, OP_SR:  result = shift_w;
         OP_SLT:         result = {{(XLEN-1){1'b0}}, lt_s};
         OP_SLTU:        result = {{(XLEN-1){1'b0}}, lt_u};
         default:        result = logic_w;
      endcase
   end

   assign wr_en = |dest_idx;

   always_comb begin
      if (op == OP_SLT || op == OP_SLTU)
         AST_SLT_ZERO_EXT: assert (result[XLEN-1:1] == '0) else $error("compare result not zero-extended"); // R5
      if (dest_idx == '0)
         AST_NO_X0_WRITE: assert (!wr_en) else $error("write to register zero"); // R6
      if (op == OP_ADD && use_imm)
         AST_IMM_NO_SUB: assert (result == opnd_a + opnd_b) else $error("immediate add subtracted"); // R4
      if (op == OP_SR && opnd_b[SHAMT_W-1:0] != '0 && !alt_sel)
         AST_SRL_ZERO_FILL: assert (!result[XLEN-1]) else $error("logical shift filled ones"); // R3
   end
endmodule

// File: tb/test_rv_int_alu.sv
module test_rv_int_alu;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opnd_a, opnd_b, result;
   logic [2:0]  op_sel;
   logic        alt_sel, use_imm, wr_en;
   logic [4:0]  dest_idx;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rv_int_alu i_rv_int_alu (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .alt_sel(alt_sel),
      .use_imm(use_imm), .dest_idx(dest_idx), .result(result), .wr_en(wr_en)
   );

   typedef struct packed {
      logic [2:0]  op;
      logic        alt;
      logic        imm;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 4'd1}, // R1 add
      '{3'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 4'd1}, // R1 wrap
      '{3'd0, 1'b1, 1'b0, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE, 4'd4}, // R4 sub
      '{3'd0, 1'b1, 1'b1, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 4'd4}, // R4 imm add
      '{3'd1, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0024, 32'h0000_0010, 4'd2}, // R2 mask
      '{3'd2, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 4'd5}, // R5 signed
      '{3'd2, 1'b0, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 4'd5}, // R5 signed
      '{3'd3, 1'b0, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001, 4'd5}, // R5 unsigned
      '{3'd3, 1'b0, 1'b1, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0000_0001, 4'd5}, // R5 imm unsigned
      '{3'd3, 1'b0, 1'b0, 32'h0000_0007, 32'h0000_0007, 32'h0000_0000, 4'd5}, // R5 equal
      '{3'd4, 1'b0, 1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FF0_0FF0, 4'd1}, // R1 xor
      '{3'd5, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_0004, 32'h0800_0000, 4'd3}, // R3 srl
      '{3'd5, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_0004, 32'hF800_0000, 4'd3}, // R3 sra
      '{3'd5, 1'b1, 1'b1, 32'h8000_0000, 32'h0000_041F, 32'hFFFF_FFFF, 4'd3}, // R3 imm sra
      '{3'd5, 1'b1, 1'b0, 32'h8765_4321, 32'h0000_0020, 32'h8765_4321, 4'd7}, // R7 by zero
      '{3'd6, 1'b0, 1'b0, 32'h0000_00F0, 32'h0000_000F, 32'h0000_00FF, 4'd1}, // R1 or
      '{3'd7, 1'b0, 1'b0, 32'h1234_5678, 32'h0000_FFFF, 32'h0000_5678, 4'd1}, // R1 and
      '{3'd7, 1'b1, 1'b0, 32'h1234_5678, 32'h0000_FFFF, 32'h0000_5678, 4'd8}, // R8 and
      '{3'd1, 1'b1, 1'b0, 32'h0000_0003, 32'h0000_0001, 32'h0000_0006, 4'd8}, // R8 sll
      '{3'd5, 1'b0, 1'b1, 32'h7FFF_FFFF, 32'h0000_001F, 32'h0000_0000, 4'd3}  // R3 imm srl
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] op, input logic alt, input logic imm,
                        input logic [31:0] a, input logic [31:0] b, input logic [4:0] rd);
      @(negedge clk);
      op_sel = op; alt_sel = alt; use_imm = imm; opnd_a = a; opnd_b = b; dest_idx = rd;
      #1;
   endtask

   initial begin
      op_sel = '0; alt_sel = 1'b0; use_imm = 1'b0; opnd_a = '0; opnd_b = '0; dest_idx = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R6 reset result", result, 32'h0);
      check("R6 reset wr_en", {31'b0, wr_en}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].op, VECS[i].alt, VECS[i].imm, VECS[i].a, VECS[i].b, 5'd5);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].exp);
      end

      apply(3'd0, 1'b0, 1'b0, 32'h1, 32'h1, 5'd0);
      check("R6 rd zero", {31'b0, wr_en}, 32'h0);
      apply(3'd0, 1'b0, 1'b0, 32'h1, 32'h1, 5'd31);
      check("R6 rd 31", {31'b0, wr_en}, 32'h1);
      check("R1 add with rd 31", result, 32'h2);

      // R7: same-cycle response, inputs changed between edges
      @(negedge clk);
      op_sel = 3'd4; opnd_a = 32'hAAAA_5555; opnd_b = 32'hFFFF_FFFF; alt_sel = 1'b0;
      #1;
      check("R7 comb xor", result, 32'h5555_AAAA);
      opnd_b = 32'h0000_0000;
      #1;
      check("R7 comb xor update", result, 32'hAAAA_5555);

      apply(3'd5, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'hFFFF_FFE0, 5'd1);
      check("R7 srl by zero", result, 32'hDEAD_BEEF);
      apply(3'd1, 1'b0, 1'b1, 32'h0000_0001, 32'hFFFF_FFFF, 5'd1);
      check("R2 sll by 31", result, 32'h8000_0000);
      apply(3'd2, 1'b1, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 5'd1);
      check("R8 slt with alt", result, 32'h1);
      apply(3'd0, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0001, 5'd1);
      check("R4 sub underflow", result, 32'hFFFF_FFFF);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=hang expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule